// File: doc/BRIEF.md
# AAL5 Cell Segmenter

This block splits a variable-length user message into a run of 48-byte cell payloads. The message arrives one byte per transfer on a valid/ready stream, framed by a start marker on its first byte and an end marker on its last. Two per-message octets, a user-to-user byte and a common-part indicator, come in beside the first byte. The block forwards the message bytes and then generates zero pad bytes and an 8-byte trailer by itself. The pad makes the message plus trailer fill a whole number of payloads.

The trailer holds the user-to-user byte, the indicator byte, the 16-bit message length and a CRC-32. The CRC-32 covers the message, the pad and the first four trailer bytes. The block marks the end of every 48-byte payload. On the final byte of the final payload it also raises an end-of-message flag, which the downstream cell builder copies into the least significant PTI bit of that cell's header.

Back-pressure rules are as follows. While message bytes flow, the input is ready exactly when the output is ready, and the output valid mirrors the input valid, so a stall on either side passes straight through. Once the end-marked byte has been taken, input ready stays low until the last trailer byte has left. While output ready is low, generated pad and trailer bytes are held.

Top module: `aal5_seg`

## Requirements
- R1: While message bytes are being taken, `in_ready` equals `out_ready`, `out_valid` equals `in_valid`, and each accepted input byte appears unchanged and in order on `out_data`.
- R2: After the byte carrying `in_eop` is accepted, the block emits P bytes of 0x00, where P = (40 − L mod 48) mod 48 and L is the message byte count (P ranges 0 to 47). `in_ready` stays 0 from then until the final trailer byte has been transferred.
- R3: The first two trailer bytes are the `in_uu` value and then the `in_cpi` value, both sampled on the accepted byte that carries `in_sop`.
- R4: Trailer bytes 3 and 4 carry the length field, high byte first. The field is L modulo 65536 and excludes pad and trailer.
- R5: Trailer bytes 5 to 8 carry the CRC-32, sent most significant byte first. The CRC uses generator 0x04C11DB7, starts from all ones and runs MSB-first over every message byte, pad byte and the first four trailer bytes. The final value is bit-inverted.
- R6: `out_cell_end` is 1 with every 48th transferred output byte of a message (byte indices 47, 95, …) and 0 with all others.
- R7: `out_eom` is 1 only with the last byte of the last payload of a message, which is also the last CRC byte.
- R8: While a pad or trailer byte is offered and `out_ready` is 0, `out_valid` stays 1 and `out_data` stays unchanged into the next cycle.
- R9: After reset, the block waits for a new message with `out_valid` following `in_valid` and `in_ready` following `out_ready`. A message cut off by reset leaves no trace in the next message's output.
- R10: In the cycle after the last trailer byte is transferred, a new message's first byte can be accepted. Its length and CRC start afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Input byte taken this cycle when both high |
| in_data | input | 8 | Message byte |
| in_sop | input | 1 | First byte of a message |
| in_eop | input | 1 | Last byte of a message |
| in_uu | input | 8 | User-to-user octet, sampled with the first byte |
| in_cpi | input | 8 | Common-part indicator octet, sampled with the first byte |
| out_valid | output | 1 | Payload byte present |
| out_ready | input | 1 | Downstream accepts the payload byte |
| out_data | output | 8 | Payload byte |
| out_cell_end | output | 1 | Byte closes a 48-byte payload |
| out_eom | output | 1 | Byte closes the last payload of the message |

## Verification
The bench builds the block with its default 48-byte payload. This makes every pad count reachable with short messages: 40 and 88 bytes need no pad, while 41 and 89 bytes need the full 47 pad bytes that spill into an extra payload. A single message of 65,600 bytes drives the length counter past its 16-bit wrap. Random stalls on both sides exercise hold behaviour in the data, pad and trailer phases, and a reset in the middle of a message checks that no state carries over.

// File: rtl/aal5_seg_pkg.sv
package aal5_seg_pkg;

  typedef enum logic [1:0] {
    PH_DATA = 2'd0,
    PH_PAD  = 2'd1,
    PH_TRL  = 2'd2
  } seg_phase_t;

  localparam logic [31:0] CRC_GEN  = 32'h04C11DB7;
  localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;
  localparam int          TRL_BYTES = 8;

  // One byte of an MSB-first CRC-32 step.
  function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    logic        fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[31] ^ b[i];
      r  = {r[30:0], 1'b0};
      if (fb) r = r ^ CRC_GEN;
    end
    return r;
  endfunction

endpackage

// File: rtl/aal5_crc32_acc.sv
module aal5_crc32_acc
  import aal5_seg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] crc_o
);

  logic [31:0] crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc_q <= CRC_SEED;
    else if (clr) crc_q <= CRC_SEED;
    else if (en)  crc_q <= crc32_step(crc_q, din);
  end

  assign crc_o = crc_q;

  // R10: a clear always leaves the seed for the next message
  a_r10_crc_seed: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (crc_o == CRC_SEED));

endmodule

// File: rtl/aal5_cell_ctr.sv
module aal5_cell_ctr #(
  parameter int CELL_BYTES = 48,
  localparam int PW = $clog2(CELL_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output logic [PW-1:0] pos_o,
  output logic          wrap_o
);

  localparam logic [PW-1:0] LAST = PW'(CELL_BYTES - 1);

  logic [PW-1:0] pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else if (step) pos_q <= (pos_q == LAST) ? '0 : pos_q + 1'b1;
  end

  assign pos_o  = pos_q;
  assign wrap_o = (pos_q == LAST);

  // R6: the payload position never leaves the payload
  a_r6_pos_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    pos_o < PW'(CELL_BYTES));

  // R6: closing a payload starts the next one at byte zero
  a_r6_wrap_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (step && wrap_o) |=> (pos_o == '0));

endmodule

// File: rtl/aal5_len_ctr.sv
module aal5_len_ctr #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [LEN_W-1:0] len_o
);

  logic [LEN_W-1:0] len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    len_q <= '0;
    else if (clr)  len_q <= '0;
    else if (inc)  len_q <= len_q + 1'b1;
  end

  assign len_o = len_q;

endmodule

// File: rtl/aal5_seg.sv
module aal5_seg
  import aal5_seg_pkg::*;
#(
  parameter int CELL_BYTES = 48
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_sop,
  input  logic       in_eop,
  input  logic [7:0] in_uu,
  input  logic [7:0] in_cpi,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_cell_end,
  output logic       out_eom
);

  localparam int PW         = $clog2(CELL_BYTES);
  localparam int DATA_SLOTS = CELL_BYTES - TRL_BYTES;
  localparam int LEN_W      = 16;
  localparam logic [PW-1:0] TRL_START = PW'(DATA_SLOTS);
  localparam logic [PW-1:0] PAD_LAST  = PW'(DATA_SLOTS - 1);

  seg_phase_t       phase_q, phase_d;
  logic [7:0]       uu_q, cpi_q;
  logic [PW-1:0]    pos;
  logic [PW-1:0]    pos_next;
  logic [PW-1:0]    trl_off;
  logic [2:0]       tidx;
  logic             cell_wrap;
  logic [31:0]      crc;
  logic [LEN_W-1:0] msg_len;
  logic             in_hs, out_hs, msg_done, crc_en;

  assign in_hs    = in_valid && in_ready;
  assign out_hs   = out_valid && out_ready;
  assign msg_done = out_hs && (phase_q == PH_TRL) && cell_wrap;
  assign trl_off  = pos - TRL_START;
  assign tidx     = trl_off[2:0];
  assign pos_next = cell_wrap ? '0 : pos + 1'b1;
  assign crc_en   = out_hs && ((phase_q != PH_TRL) || (tidx < 3'd4));

  aal5_cell_ctr #(.CELL_BYTES(CELL_BYTES)) u_pos (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (out_hs),
    .pos_o  (pos),
    .wrap_o (cell_wrap)
  );

  aal5_len_ctr #(.LEN_W(LEN_W)) u_len (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (msg_done),
    .inc   (in_hs),
    .len_o (msg_len)
  );

  aal5_crc32_acc u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (msg_done),
    .en    (crc_en),
    .din   (out_data),
    .crc_o (crc)
  );

  // Per-message octets sampled with the first byte
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uu_q  <= '0;
      cpi_q <= '0;
    end else if (in_hs && in_sop) begin
      uu_q  <= in_uu;
      cpi_q <= in_cpi;
    end
  end

  // Trailer byte selection
  logic [7:0] trl_byte;
  always_comb begin
    unique case (tidx)
      3'd0: trl_byte = uu_q;
      3'd1: trl_byte = cpi_q;
      3'd2: trl_byte = msg_len[15:8];
      3'd3: trl_byte = msg_len[7:0];
      3'd4: trl_byte = ~crc[31:24];
      3'd5: trl_byte = ~crc[23:16];
      3'd6: trl_byte = ~crc[15:8];
      default: trl_byte = ~crc[7:0];
    endcase
  end

  // Stream steering
  always_comb begin
    in_ready  = 1'b0;
    out_valid = 1'b0;
    out_data  = 8'h00;
    unique case (phase_q)
      PH_DATA: begin
        in_ready  = out_ready;
        out_valid = in_valid;
        out_data  = in_data;
      end
      PH_PAD: begin
        out_valid = 1'b1;
        out_data  = 8'h00;
      end
      default: begin
        out_valid = 1'b1;
        out_data  = trl_byte;
      end
    endcase
  end

  assign out_cell_end = out_valid && cell_wrap;
  assign out_eom      = out_valid && cell_wrap && (phase_q == PH_TRL);

  // Phase sequencing
  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_DATA: if (in_hs && in_eop)
                 phase_d = (pos_next == TRL_START) ? PH_TRL : PH_PAD;
      PH_PAD:  if (out_hs && pos == PAD_LAST) phase_d = PH_TRL;
      default: if (out_hs && cell_wrap)       phase_d = PH_DATA;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_DATA;
    else        phase_q <= phase_d;
  end

  // R1: the input can only move when the output can
  a_r1_ready_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> out_ready);

  // R2: no input is taken once the end byte is in
  a_r2_closed_after_eop: assert property (@(posedge clk) disable iff (!rst_n)
    (in_hs && in_eop) |=> !in_ready);

  // R2: the trailer always sits in the final slots of a payload
  a_r2_trailer_slots: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_TRL) |-> (pos >= TRL_START));

  // R7: end-of-message only ever closes a payload
  a_r7_eom_closes_cell: assert property (@(posedge clk) disable iff (!rst_n)
    out_eom |-> out_cell_end);

  // R8: generated bytes hold under a stall
  a_r8_hold_generated: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_DATA && out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R10: the next message starts with a cleared length
  a_r10_len_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (out_hs && out_eom) |=> (phase_q == PH_DATA && msg_len == '0));

endmodule

// File: tb/tb_aal5_seg.sv
`timescale 1ns/1ps
module tb_aal5_seg;

  localparam int CB = 48;
  localparam int NV = 10;
  // Stimulus: length, uu, cpi, stall mode; expected: total output bytes
  localparam int          LEN_T  [NV] = '{1, 40, 41, 47, 48, 88, 89, 100, 7, 136};
  localparam int          TOT_T  [NV] = '{48, 48, 96, 96, 96, 96, 144, 144, 48, 144};
  localparam logic [7:0]  UU_T   [NV] = '{8'h11, 8'hA5, 8'h00, 8'hFF, 8'h3C, 8'h81, 8'h42, 8'h7E, 8'hC3, 8'h09};
  localparam logic [7:0]  CPI_T  [NV] = '{8'h00, 8'h5A, 8'h01, 8'hFF, 8'hC3, 8'h18, 8'h24, 8'h00, 8'h3C, 8'h90};
  localparam int          MODE_T [NV] = '{0, 1, 1, 0, 1, 1, 0, 1, 1, 1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, out_ready = 1'b1;
  logic [7:0] in_data = 8'h00, in_uu = 8'h00, in_cpi = 8'h00;
  logic in_ready, out_valid, out_cell_end, out_eom;
  logic [7:0] out_data;

  int errors = 0;
  int checks = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  aal5_seg dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop), .in_uu(in_uu), .in_cpi(in_cpi),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_cell_end(out_cell_end), .out_eom(out_eom)
  );

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    logic fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[31] ^ b[i];
      r = {r[30:0], 1'b0};
      if (fb) r = r ^ 32'h04C11DB7;
    end
    return r;
  endfunction

  function automatic logic [7:0] dbyte(input int seed, input int i);
    return 8'(i * 13 + seed * 29 + (i >> 8));
  endfunction

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic run_msg(input int seed, input int L, input logic [7:0] uu, input logic [7:0] cpi,
                         input int total, input int mode);
    int P, N, k, sent, cyc, t;
    logic acc, stalled, first;
    logic [7:0] held, e;
    logic [31:0] crc;
    string tag;
    P = (40 - (L % CB) + CB) % CB;
    N = L + P + 8;
    chk(N == total, "R2 total bytes", N, total);
    k = 0; sent = 0; cyc = 0; acc = 1'b0; stalled = 1'b0; first = 1'b1;
    crc = 32'hFFFF_FFFF;
    in_uu = uu; in_cpi = cpi;
    while (k < N && cyc < 4 * N + 200) begin
      @(negedge clk);
      cyc++;
      step_lfsr();
      if (acc) begin sent++; in_valid = 1'b0; acc = 1'b0; end
      out_ready = (mode == 0) ? 1'b1 : (lfsr[0] | lfsr[3]);
      if (!in_valid && sent < L && (mode == 0 || lfsr[1] || lfsr[5])) begin
        in_valid = 1'b1;
        in_data  = dbyte(seed, sent);
        in_sop   = (sent == 0);
        in_eop   = (sent == L - 1);
      end
      #1;
      if (stalled)
        chk(out_valid && out_data == held, "R8 held byte", out_data, held);
      stalled = 1'b0;
      if (first) chk(in_ready == out_ready, "R10 accept after previous end", in_ready, out_ready);
      first = 1'b0;
      if (sent < L) begin
        chk(in_ready == out_ready, "R1 ready passthrough", in_ready, out_ready);
        chk(out_valid == in_valid, "R1 valid passthrough", out_valid, in_valid);
      end else begin
        chk(!in_ready, "R2 input closed", in_ready, 0);
        if (out_valid && !out_ready) begin stalled = 1'b1; held = out_data; end
      end
      if (out_valid && out_ready) begin
        if (k < L) begin e = dbyte(seed, k); tag = "R1 data"; end
        else if (k < L + P) begin e = 8'h00; tag = "R2 pad"; end
        else begin
          t = k - L - P;
          case (t)
            0: begin e = uu; tag = "R3 uu"; end
            1: begin e = cpi; tag = "R3 cpi"; end
            2: begin e = 8'(L >> 8); tag = "R4 len hi"; end
            3: begin e = 8'(L); tag = "R4 len lo"; end
            4: begin e = ~crc[31:24]; tag = "R5 crc"; end
            5: begin e = ~crc[23:16]; tag = "R5 crc"; end
            6: begin e = ~crc[15:8]; tag = "R5 crc"; end
            default: begin e = ~crc[7:0]; tag = "R5 crc"; end
          endcase
        end
        chk(out_data == e, tag, out_data, e);
        chk(out_cell_end == ((k % CB) == CB - 1), "R6 cell end", out_cell_end, (k % CB) == CB - 1);
        chk(out_eom == (k == N - 1), "R7 eom", out_eom, k == N - 1);
        if (k < L + P + 4) crc = ref_crc(crc, e);
        k++;
      end
      if (in_valid && in_ready) acc = 1'b1;
    end
    if (acc) begin sent++; in_valid = 1'b0; end
    chk(k == N, "R2 message completed", k, N);
    in_valid = 1'b0;
  endtask

  initial begin
    #(4 * 190000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(out_valid == 1'b0, "R9 idle out_valid", out_valid, 0);
    chk(in_ready == 1'b1, "R9 idle in_ready", in_ready, 1);

    for (int v = 0; v < NV; v++)
      run_msg(v, LEN_T[v], UU_T[v], CPI_T[v], TOT_T[v], MODE_T[v]);

    // R9: reset in the middle of a message, then a clean short message
    out_ready = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = 8'(i + 1); in_sop = (i == 0); in_eop = 1'b0;
      in_uu = 8'hEE; in_cpi = 8'hDD;
    end
    @(negedge clk);
    in_valid = 1'b0; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(out_valid == 1'b0, "R9 after mid-message reset", out_valid, 0);
    run_msg(77, 5, 8'h12, 8'h34, 48, 1);

    // R4: length field wraps past 65535 (65600 bytes, 8 pad bytes)
    run_msg(3, 65600, 8'h5C, 8'hA3, 65616, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule